// File: doc/BRIEF.md
# Discarded Way Record Backup Buffer

When a base register takes a new value, its entry in the per-register way record table stops being valid. This block keeps such discarded records so they are not lost. It is a small direct-mapped store. Each slot holds the full register value that the record belonged to, the offset bound, and a cache line pointer (set and way). If the register later returns to a value that was seen before, a probe with that value finds the record again. The record then goes back to the table without a normal tagged cache access.

The buffer sits in the writeback stage. The slot is chosen by the register value bits just above the line-offset bits. A hit needs a compare of the whole register value. A hit moves the record out of the buffer, so the slot is freed. Coherence is kept in two ways. A line-eviction notice names a cache line pointer, and every slot that points at that line is dropped. A global flush empties the whole buffer.

Top module: `wayrec_backup`

## Requirements
- R1: After a synchronous reset every slot is empty, so any probe misses.
- R2: A probe with `prb_en` high reports the record in the same cycle on `prb_hit`, `prb_bound` and `prb_ptr`. The record must have been inserted in an earlier cycle with the same register value.
- R3: The slot index is register value bits [LINE_OFF+log2(DEPTH)-1 : LINE_OFF], which is bits [9:6] by default. A value that shares the index but differs in any other bit, including the low line-offset bits, misses.
- R4: An insert to an occupied slot replaces the old record. The old value then misses and the new value hits.
- R5: A probe hit removes the record, so an identical probe in the next cycle misses.
- R6: An insert and a probe hit to the same slot can happen in the same cycle. The probe returns the old record, and the inserted record stays in the slot afterwards.
- R7: An invalidate with `inv_ptr` empties every slot whose line pointer equals `inv_ptr`, however many there are. Slots with other pointers are untouched.
- R8: A probe in the same cycle as an invalidate naming the matching slot's pointer misses.
- R9: A flush empties every slot. A probe in the flush cycle misses, and an insert in the flush cycle is dropped.
- R10: Whenever `prb_hit` is low, `prb_bound` and `prb_ptr` are zero.
- R11: With `prb_en` low there is no hit and no slot is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Store a discarded record |
| ins_value | input | 64 | Register value the record belonged to |
| ins_bound | input | 16 | Offset bound of the record |
| ins_ptr | input | 9 | Cache line pointer (set and way) of the record |
| prb_en | input | 1 | Look up a new register value |
| prb_value | input | 64 | New register value |
| prb_hit | output | 1 | Record restored |
| prb_bound | output | 16 | Restored bound |
| prb_ptr | output | 9 | Restored line pointer |
| inv_en | input | 1 | A cache line was evicted or invalidated |
| inv_ptr | input | 9 | Pointer of that line |
| flush | input | 1 | Empty the whole buffer |

## Verification
Collisions within one cycle are the hardest cases to reach from the ports. The first is an insert and a consuming probe hit on the same slot. The second is an eviction notice that lands while a probe would hit the record it names. The bench builds a known slot state over several single-cycle steps and then drives the conflicting operations together in one cycle. It checks the combinational probe result in that cycle, and then probes again to show which record survived. The eviction test places the same pointer in several slots so that a multi-slot clear is visible.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    localparam int REG_W   = 64;
    localparam int BOUND_W = 16;
    localparam int PTR_W   = 9;

    typedef struct packed {
        logic [REG_W-1:0]   value;
        logic [BOUND_W-1:0] bound;
        logic [PTR_W-1:0]   ptr;
    } wrb_rec_t;

    // register value shifted so the slot index sits at bit 0
    function automatic logic [REG_W-1:0] slot_bits(input logic [REG_W-1:0] v, input int off);
        return v >> off;
    endfunction
endpackage

// File: rtl/wrb_store.sv
module wrb_store
    import wrb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  wrb_rec_t                wr_rec,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    input  logic                    inv_en,
    input  logic [PTR_W-1:0]        inv_ptr,
    output logic [DEPTH-1:0]        valid_q,
    output wrb_rec_t [DEPTH-1:0]    rec_q
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic wr_hit, clr_hit, inv_hit;
        assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(gi));
        assign clr_hit = clr_en && (clr_idx == IDX_W'(gi));
        assign inv_hit = inv_en && (rec_q[gi].ptr == inv_ptr);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                valid_q[gi] <= 1'b0;
            end else if (wr_hit) begin
                valid_q[gi] <= 1'b1;          // insert beats consume and evict
            end else if (clr_hit || inv_hit) begin
                valid_q[gi] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rec_q[gi] <= '0;
            end else if (wr_hit && !flush) begin
                rec_q[gi] <= wr_rec;
            end
        end
    end
endmodule

// File: rtl/wrb_lookup.sv
module wrb_lookup
    import wrb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic                  prb_en,
    input  logic [REG_W-1:0]      prb_value,
    input  logic [IDX_W-1:0]      prb_idx,
    input  logic                  flush,
    input  logic                  inv_en,
    input  logic [PTR_W-1:0]      inv_ptr,
    input  logic [DEPTH-1:0]      valid_q,
    input  wrb_rec_t [DEPTH-1:0]  rec_q,
    output logic                  hit,
    output logic [BOUND_W-1:0]    bound,
    output logic [PTR_W-1:0]      ptr
);
    wrb_rec_t sel;
    logic     stale;

    always_comb begin
        sel   = rec_q[prb_idx];
        stale = flush || (inv_en && (sel.ptr == inv_ptr));
        hit   = prb_en && valid_q[prb_idx] && (sel.value == prb_value) && !stale;
        bound = hit ? sel.bound : '0;
        ptr   = hit ? sel.ptr   : '0;
    end
endmodule

// File: rtl/wayrec_backup.sv
module wayrec_backup
    import wrb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LINE_OFF = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_en,
    input  logic [REG_W-1:0]   ins_value,
    input  logic [BOUND_W-1:0] ins_bound,
    input  logic [PTR_W-1:0]   ins_ptr,
    input  logic               prb_en,
    input  logic [REG_W-1:0]   prb_value,
    output logic               prb_hit,
    output logic [BOUND_W-1:0] prb_bound,
    output logic [PTR_W-1:0]   prb_ptr,
    input  logic               inv_en,
    input  logic [PTR_W-1:0]   inv_ptr,
    input  logic               flush
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]     ins_idx, prb_idx;
    wrb_rec_t             ins_rec;
    logic [DEPTH-1:0]     valid_q;
    wrb_rec_t [DEPTH-1:0] rec_q;

    assign ins_idx = IDX_W'(slot_bits(ins_value, LINE_OFF));
    assign prb_idx = IDX_W'(slot_bits(prb_value, LINE_OFF));
    assign ins_rec = '{value: ins_value, bound: ins_bound, ptr: ins_ptr};

    wrb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (ins_en),
        .wr_idx  (ins_idx),
        .wr_rec  (ins_rec),
        .clr_en  (prb_hit),
        .clr_idx (prb_idx),
        .inv_en  (inv_en),
        .inv_ptr (inv_ptr),
        .valid_q (valid_q),
        .rec_q   (rec_q)
    );

    wrb_lookup #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_lookup (
        .prb_en    (prb_en),
        .prb_value (prb_value),
        .prb_idx   (prb_idx),
        .flush     (flush),
        .inv_en    (inv_en),
        .inv_ptr   (inv_ptr),
        .valid_q   (valid_q),
        .rec_q     (rec_q),
        .hit       (prb_hit),
        .bound     (prb_bound),
        .ptr       (prb_ptr)
    );
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker
    import wrb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LINE_OFF = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               ins_en,
    input logic [REG_W-1:0]   ins_value,
    input logic               prb_en,
    input logic [REG_W-1:0]   prb_value,
    input logic               prb_hit,
    input logic [BOUND_W-1:0] prb_bound,
    input logic [PTR_W-1:0]   prb_ptr,
    input logic               inv_en,
    input logic [PTR_W-1:0]   inv_ptr,
    input logic               flush
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    logic same_slot;
    assign same_slot = IDX_W'(slot_bits(ins_value, LINE_OFF)) == IDX_W'(slot_bits(prb_value, LINE_OFF));

    a_r1_empty_after_reset: assert property (@(posedge clk) rst |=> !prb_hit);
    a_r10_zero_on_miss: assert property (@(posedge clk) disable iff (rst)
        !prb_hit |-> (prb_bound == '0 && prb_ptr == '0));
    a_r11_idle_no_hit: assert property (@(posedge clk) disable iff (rst) !prb_en |-> !prb_hit);
    a_r9_flush_cycle_miss: assert property (@(posedge clk) disable iff (rst) flush |-> !prb_hit);
    a_r9_flush_next_miss: assert property (@(posedge clk) disable iff (rst) flush |=> !prb_hit);
    a_r8_evicted_not_restored: assert property (@(posedge clk) disable iff (rst)
        (inv_en && prb_hit) |-> (prb_ptr != inv_ptr));
    a_r5_hit_consumes: assert property (@(posedge clk) disable iff (rst)
        (prb_hit && !(ins_en && same_slot)) |=> !(prb_hit && prb_value == $past(prb_value)));
endmodule

bind wayrec_backup wrb_checker #(.DEPTH(DEPTH), .LINE_OFF(LINE_OFF)) u_wrb_checker (
    .clk       (clk),
    .rst       (rst),
    .ins_en    (ins_en),
    .ins_value (ins_value),
    .prb_en    (prb_en),
    .prb_value (prb_value),
    .prb_hit   (prb_hit),
    .prb_bound (prb_bound),
    .prb_ptr   (prb_ptr),
    .inv_en    (inv_en),
    .inv_ptr   (inv_ptr),
    .flush     (flush)
);

// File: tb/test_wayrec_backup.sv
`timescale 1ns/1ps
module test_wayrec_backup;
    import wrb_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               ins_en, prb_en, inv_en, flush;
    logic [REG_W-1:0]   ins_value, prb_value;
    logic [BOUND_W-1:0] ins_bound, prb_bound;
    logic [PTR_W-1:0]   ins_ptr, prb_ptr, inv_ptr;
    logic               prb_hit;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    wayrec_backup i_wayrec_backup (
        .clk(clk), .rst(rst),
        .ins_en(ins_en), .ins_value(ins_value), .ins_bound(ins_bound), .ins_ptr(ins_ptr),
        .prb_en(prb_en), .prb_value(prb_value),
        .prb_hit(prb_hit), .prb_bound(prb_bound), .prb_ptr(prb_ptr),
        .inv_en(inv_en), .inv_ptr(inv_ptr), .flush(flush)
    );

    // slot 1 values (bits [9:6] = 1)
    localparam logic [63:0] VA  = 64'h0000_0000_1000_0040;
    localparam logic [63:0] VA2 = 64'h0000_0000_2000_0040;
    localparam logic [63:0] VA3 = 64'h0000_0000_1000_0041;
    localparam logic [63:0] VB  = 64'h0000_0000_1000_0080; // slot 2
    localparam logic [63:0] VC  = 64'h0000_0000_1000_00C0; // slot 3

    task automatic quiet();
        ins_en = 0; prb_en = 0; inv_en = 0; flush = 0;
        ins_value = '0; ins_bound = '0; ins_ptr = '0;
        prb_value = '0; inv_ptr = '0;
    endtask

    // each step: start at negedge with all inputs idle
    task automatic begin_step();
        @(negedge clk);
        quiet();
    endtask

    task automatic set_ins(input logic [63:0] v, input logic [15:0] b, input logic [8:0] p);
        ins_en = 1; ins_value = v; ins_bound = b; ins_ptr = p;
    endtask

    task automatic insert(input logic [63:0] v, input logic [15:0] b, input logic [8:0] p);
        begin_step();
        set_ins(v, b, p);
    endtask

    task automatic expect_probe(input string req, input logic eh, input logic [15:0] eb, input logic [8:0] ep);
        #1;
        checks++;
        if (prb_hit !== eh || prb_bound !== eb || prb_ptr !== ep) begin
            errors++;
            $display("FAIL %s: actual hit=%0b bound=%h ptr=%h, expected hit=%0b bound=%h ptr=%h",
                     req, prb_hit, prb_bound, prb_ptr, eh, eb, ep);
        end
    endtask

    task automatic probe(input string req, input logic [63:0] v, input logic eh,
                         input logic [15:0] eb, input logic [8:0] ep);
        begin_step();
        prb_en = 1; prb_value = v;
        expect_probe(req, eh, eb, ep);
    endtask

    task automatic do_reset();
        @(negedge clk);
        quiet();
        rst = 1;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        insert(VA, 16'h0011, 9'h011);
        do_reset();
        probe("R1 empty after reset", VA, 0, 0, 0);
        probe("R10 miss drives zero", VB, 0, 0, 0);
    endtask

    task automatic t_basic();
        insert(VA, 16'h0038, 9'h005);
        probe("R2 restore", VA, 1, 16'h0038, 9'h005);
        probe("R5 consumed", VA, 0, 0, 0);
    endtask

    task automatic t_full_compare();
        insert(VA, 16'h0123, 9'h044);
        probe("R3 offset bits differ", VA3, 0, 0, 0);
        probe("R3 upper bits differ", VA2, 0, 0, 0);
        probe("R3 exact value", VA, 1, 16'h0123, 9'h044);
    endtask

    task automatic t_replace();
        insert(VA, 16'h0001, 9'h001);
        insert(VA2, 16'h0002, 9'h002);
        probe("R4 old value gone", VA, 0, 0, 0);
        probe("R4 new value", VA2, 1, 16'h0002, 9'h002);
    endtask

    task automatic t_collision();
        insert(VA, 16'h00AA, 9'h0AA);
        begin_step();
        set_ins(VA2, 16'h00BB, 9'h0BB);
        prb_en = 1; prb_value = VA;
        expect_probe("R6 probe sees old", 1, 16'h00AA, 9'h0AA);
        probe("R6 insert kept", VA2, 1, 16'h00BB, 9'h0BB);
    endtask

    task automatic t_evict();
        insert(VA, 16'h0010, 9'h007);
        insert(VB, 16'h0020, 9'h007);
        insert(VC, 16'h0030, 9'h009);
        begin_step();
        inv_en = 1; inv_ptr = 9'h007;
        probe("R7 evicted slot 1", VA, 0, 0, 0);
        probe("R7 evicted slot 2", VB, 0, 0, 0);
        probe("R7 other pointer kept", VC, 1, 16'h0030, 9'h009);
    endtask

    task automatic t_evict_race();
        insert(VA, 16'h0040, 9'h003);
        begin_step();
        prb_en = 1; prb_value = VA; inv_en = 1; inv_ptr = 9'h003;
        expect_probe("R8 same-cycle evict", 0, 0, 0);
        probe("R8 record dropped", VA, 0, 0, 0);
        insert(VB, 16'h0050, 9'h004);
        begin_step();
        prb_en = 1; prb_value = VB; inv_en = 1; inv_ptr = 9'h005;
        expect_probe("R8 unrelated evict", 1, 16'h0050, 9'h004);
    endtask

    task automatic t_flush();
        insert(VA, 16'h0060, 9'h010);
        insert(VB, 16'h0070, 9'h011);
        begin_step();
        flush = 1; prb_en = 1; prb_value = VA;
        set_ins(VC, 16'h0080, 9'h012);
        expect_probe("R9 flush cycle miss", 0, 0, 0);
        probe("R9 slot cleared", VB, 0, 0, 0);
        probe("R9 insert dropped", VC, 0, 0, 0);
    endtask

    task automatic t_disabled();
        insert(VA, 16'h0090, 9'h020);
        begin_step();
        prb_value = VA;
        expect_probe("R11 disabled probe", 0, 0, 0);
        probe("R11 not consumed", VA, 1, 16'h0090, 9'h020);
    endtask

    initial begin
        quiet();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_full_compare();
        t_replace();
        t_collision();
        t_evict();
        t_evict_race();
        t_flush();
        t_disabled();
        begin_step();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule